// File: doc/BRIEF.md
# Recirculating Shuffle-Exchange Rotator

This block rotates a vector of N data words (N a power of two) by a requested number of positions. It has one physical stage: a perfect-shuffle wiring pattern followed by a column of N/2 two-input exchange switches. The stage output is fed back into its input, so the data makes log2(N) passes through the same hardware. Over time this behaves like an unrolled multistage network. Each pass takes one clock cycle.

Each word travels with a small routing tag that holds its destination address, (i + k) mod N. On every pass, each exchange switch reads one bit of the tag arriving on its upper input. This bit tells the switch whether to pass or swap the pair. The switch settings for every pass therefore come from the shift amount alone, with no stored tables. Successive passes use the tag bits from the most significant down to the least significant.

A vector enters on a valid/ready handshake and the rotated vector leaves on a second valid/ready handshake. The input is refused (`in_ready` low) from the cycle after acceptance until the result has been taken. The result is held steady for as long as `out_ready` stays low.

Top module: `shx_rotator`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A vector is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the edge where the result handshake completes.
- R3: `out_valid` rises exactly log2(N) clock edges after the accepting edge, one pass per cycle.
- R4: Input word i occupies `in_data[i*W +: W]`. Output word p occupies `out_data[p*W +: W]`. With shift amount k taken from `in_shift` at acceptance, output word (i + k) mod N equals input word i for every i, and no two words contend for one exchange output in any pass.
- R5: Every shift amount from 0 to N-1 is realised, including 0 (identity) and, for N=8, the amounts 2 and 3. Each takes the same log2(N) passes.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. The result handshake completes on an edge where both are 1, and `in_ready` is 1 in the following cycle.
- R7: `in_valid`, `in_data` and `in_shift` are ignored while `in_ready` is 0. Changing them during a rotation or a stalled result does not alter that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector and shift amount are valid |
| in_ready | output | 1 | Block can accept a vector |
| in_data | input | N*W | Input vector, word i at bits i*W +: W |
| in_shift | input | log2(N) | Rotation amount k |
| out_valid | output | 1 | Rotated vector available (done) |
| out_ready | input | 1 | Consumer takes the rotated vector |
| out_data | output | N*W | Rotated vector, word p at bits p*W +: W |

## Verification
The hardest situation to reach from the ports is a result that must stay frozen while a new vector is pressed against the input, because the block has to ignore new data during back-pressure. The stimulus creates this case by withholding `out_ready` for several cycles after completion. During those cycles, and during the passes before them, it holds `in_valid` high with complemented data and a different shift amount. Every shift amount is also swept with a distinct data pattern. A behavioural queue model is compared against `in_ready`, `out_valid` and `out_data` on every cycle.

// File: rtl/shx_pkg.sv
package shx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD
  } shx_state_e;

  // Source position feeding shuffled position q: inverse of a one-bit left
  // rotation of an lg-bit address, i.e. a one-bit right rotation.
  function automatic int shuf_src(input int q, input int lg);
    return (q >> 1) | ((q & 1) << (lg - 1));
  endfunction

endpackage

// File: rtl/shx_stage.sv
// One combinational pass: perfect shuffle, then a column of exchange switches
// each steered by the selected tag bit of the word on its upper input.
module shx_stage #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int LOGN = $clog2(N)
) (
  input  logic [W-1:0]    d_in  [N],
  input  logic [LOGN-1:0] t_in  [N],
  input  logic [LOGN-1:0] sel_mask,
  output logic [W-1:0]    d_out [N],
  output logic [LOGN-1:0] t_out [N]
);

  logic [W-1:0]    sh_d [N];
  logic [LOGN-1:0] sh_t [N];

  for (genvar q = 0; q < N; q++) begin : g_shuffle
    assign sh_d[q] = d_in[shx_pkg::shuf_src(q, LOGN)];
    assign sh_t[q] = t_in[shx_pkg::shuf_src(q, LOGN)];
  end

  for (genvar j = 0; j < N / 2; j++) begin : g_exchange
    logic swap;
    assign swap         = |(sh_t[2*j] & sel_mask);
    assign d_out[2*j]   = swap ? sh_d[2*j+1] : sh_d[2*j];
    assign d_out[2*j+1] = swap ? sh_d[2*j]   : sh_d[2*j+1];
    assign t_out[2*j]   = swap ? sh_t[2*j+1] : sh_t[2*j];
    assign t_out[2*j+1] = swap ? sh_t[2*j]   : sh_t[2*j+1];
  end

endmodule

// File: rtl/shx_ctrl.sv
// Sequencer: accepts a vector, runs LOGN passes with a walking bit-select
// mask (MSB first), then holds the result until it is taken.
module shx_ctrl #(
  parameter int N = 8,
  localparam int LOGN = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            out_ready,
  output logic            in_ready,
  output logic            out_valid,
  output logic            load,
  output logic            step,
  output logic [LOGN-1:0] sel_mask
);
  import shx_pkg::*;

  shx_state_e state_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign load      = in_ready && in_valid;
  assign step      = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sel_mask <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q  <= ST_RUN;
          sel_mask <= {1'b1, {(LOGN-1){1'b0}}};
        end
        ST_RUN: begin
          sel_mask <= sel_mask >> 1;
          if (sel_mask[0]) state_q <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/shx_rotator.sv
module shx_rotator #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int LOGN = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N*W-1:0]  in_data,
  input  logic [LOGN-1:0] in_shift,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N*W-1:0]  out_data
);

  logic            load, step;
  logic [LOGN-1:0] sel_mask;
  logic [W-1:0]    data_q [N];
  logic [LOGN-1:0] tag_q  [N];
  logic [W-1:0]    data_nxt [N];
  logic [LOGN-1:0] tag_nxt  [N];
  logic [W-1:0]    in_w     [N];
  logic [LOGN-1:0] tag_init [N];

  shx_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step),
    .sel_mask  (sel_mask)
  );

  shx_stage #(.N(N), .W(W)) u_stage (
    .d_in     (data_q),
    .t_in     (tag_q),
    .sel_mask (sel_mask),
    .d_out    (data_nxt),
    .t_out    (tag_nxt)
  );

  for (genvar i = 0; i < N; i++) begin : g_lanes
    assign in_w[i]            = in_data[i*W +: W];
    assign tag_init[i]        = LOGN'(i) + in_shift;
    assign out_data[i*W +: W] = data_q[i];
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= in_w;
      tag_q  <= tag_init;
    end else if (step) begin
      data_q <= data_nxt;
      tag_q  <= tag_nxt;
    end
  end

endmodule

// File: rtl/shx_rotator_chk.sv
module shx_rotator_chk #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int LOGN = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [N*W-1:0]  out_data,
  input logic            step,
  input logic [LOGN-1:0] sel_mask,
  input logic [LOGN-1:0] tag_q [N]
);

  int  lat_cnt;
  logic inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt  <= 0;
      inflight <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat_cnt  <= 0;
      inflight <= 1'b1;
    end else if (inflight && !out_valid) begin
      lat_cnt  <= lat_cnt + 1;
    end else if (out_valid) begin
      inflight <= 1'b0;
    end
  end

  // R3: result appears exactly LOGN cycles after acceptance
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_cnt == LOGN);

  // R2: no acceptance while a result is pending
  a_r2_ready_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R6: stalled result stays put
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: handshake frees the input side
  a_r6_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  for (genvar j = 0; j < N / 2; j++) begin : g_pair
    // R4: the two words meeting at one switch want opposite outputs
    a_r4_pairs_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> ((|(tag_q[shx_pkg::shuf_src(2*j, LOGN)] & sel_mask)) !=
                (|(tag_q[shx_pkg::shuf_src(2*j+1, LOGN)] & sel_mask))));
  end

  for (genvar i = 0; i < N; i++) begin : g_home
    // R4: every word has reached the slot named by its tag
    a_r4_tag_home: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> tag_q[i] == LOGN'(i));
  end

endmodule

bind shx_rotator shx_rotator_chk #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .step      (step),
  .sel_mask  (sel_mask),
  .tag_q     (tag_q)
);

// File: tb/shx_rotator_tb.sv
module shx_rotator_tb;
  localparam int N = 8;
  localparam int W = 8;
  localparam int LOGN = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [N*W-1:0]  in_data = '0;
  logic [LOGN-1:0] in_shift = '0;
  logic in_ready, out_valid;
  logic [N*W-1:0] out_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string data_tag = "R4";

  always #5 clk = ~clk;

  shx_rotator #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_shift(in_shift), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // Behavioural reference: 0 idle, 1 rotating, 2 holding
  int m_state = 0;
  int m_cnt = 0;
  logic [N*W-1:0] m_q;
  bit m_stalled = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_state   <= 0;
      m_stalled <= 0;
    end else begin
      case (m_state)
        0: if (in_valid) begin
          for (int i = 0; i < N; i++)
            m_q[((i + int'(in_shift)) % N)*W +: W] <= in_data[i*W +: W];
          m_cnt   <= 1;
          m_state <= 1;
        end
        1: begin
          if (m_cnt == LOGN) m_state <= 2;
          m_cnt <= m_cnt + 1;
        end
        default: begin
          m_stalled <= !out_ready;
          if (out_ready) begin m_state <= 0; m_stalled <= 0; end
        end
      endcase
    end
  end

  task automatic chk(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 in_ready", {{(N*W-1){1'b0}}, in_ready}, {{(N*W-1){1'b0}}, m_state == 0});
      chk("R3 out_valid", {{(N*W-1){1'b0}}, out_valid}, {{(N*W-1){1'b0}}, m_state == 2});
      if (m_state == 2)
        chk(m_stalled ? "R6 stalled data" : data_tag, out_data, m_q);
    end
  end

  function automatic logic [N*W-1:0] pat(int seed);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(seed * 37 + i * 29 + 5);
    return v;
  endfunction

  task automatic send(int k, int seed, int stall, bit junk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = pat(seed);
    in_shift = LOGN'(k);
    @(negedge clk);
    if (junk) begin
      in_data  = ~in_data;
      in_shift = LOGN'(k + 1);
    end else in_valid = 1'b0;
    out_ready = (stall == 0);
    while (!out_valid) @(negedge clk);
    repeat (stall) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 in_ready in reset", {{(N*W-1){1'b0}}, in_ready}, {{(N*W-1){1'b0}}, 1'b1});
    chk("R1 out_valid in reset", {{(N*W-1){1'b0}}, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after reset", {{(N*W-1){1'b0}}, in_ready}, {{(N*W-1){1'b0}}, 1'b1});

    // R5: every shift amount, identity and 2/3 included
    data_tag = "R5 sweep";
    for (int k = 0; k < N; k++) send(k, k + 1, 0, 1'b0);
    data_tag = "R4 second sweep";
    for (int k = N - 1; k >= 0; k--) send(k, 40 + k, 1, 1'b0);

    // R7: inputs pressed during rotation and stall are ignored
    data_tag = "R7 ignored input";
    send(3, 91, 4, 1'b1);
    send(2, 92, 2, 1'b1);
    send(5, 93, 0, 1'b1);
    send(0, 94, 6, 1'b1);

    data_tag = "R4 back to back";
    send(7, 120, 0, 1'b0);
    send(1, 121, 0, 1'b0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule